// File: doc/BRIEF.md
# Planar Tile Colour Raster Unit

This block sits between a CPU and a bitmap memory split into four colour planes. It speeds up two common drawing jobs: filling pixels with one colour across all planes in a single CPU access, and finding which pixels of a byte or word hold a given colour. Software loads a mode byte and four 8-bit tile bytes, one colour bit pattern per plane, through a small I/O port. While the raster function is on, a CPU write becomes a multi-plane operation. In merge mode the CPU data acts as a bit mask that blends each plane's tile into the stored pixels. In direct mode the tile bytes are written straight into all enabled planes. A CPU read in direct mode returns a colour-match vector instead of memory contents.

While the raster function is off, each CPU access reaches the single plane named by the top two address bits. Word accesses at odd addresses are split into two byte accesses. Every access holds `cpu_ready` low until its memory cycles have finished. Reads use a synchronous memory whose data appears one cycle after the request.

Top module: `tile_raster_unit`

## Requirements
- R1: After reset the mode byte is zero, so the raster function is off and every plane is enabled. The tile pointer is zero, `cpu_ready` is high, `mem_en` is low and `cpu_rdata` is zero.
- R2: An I/O write with `io_sel`=1 stores `io_wdata` in the tile of the plane at the tile pointer, then advances the pointer modulo 4. An I/O write with `io_sel`=0 loads the mode byte and returns the pointer to zero.
- R3: Mode byte fields: bit 7 turns the raster function on, and bit 6 selects merge mode (1) or direct mode (0). Bit i of bits 3:0 set to 1 removes plane i from raster operations. Bits 5:4 have no effect.
- R4: In merge mode a CPU write stores (old & ~data) | (tile & data) in every enabled plane. Word writes use each tile byte copied into both halves. Disabled planes keep their contents.
- R5: In direct mode a CPU write stores each enabled plane's tile byte at the addressed byte or bytes. The CPU data has no effect, and disabled planes keep their contents.
- R6: In direct mode a CPU read returns, for each bit, 1 when every enabled plane matches its tile at that bit, otherwise 0. This is the inverted OR over enabled planes of (plane XOR tile), in both byte and word form. With all planes disabled the result is all ones.
- R7: In merge mode a CPU read returns the plain byte or word of the plane selected by address bits [top:top-1].
- R8: With the raster function off, reads and writes reach only the plane selected by the top two address bits, at the byte offset given by the lower bits.
- R9: A word access at an odd address acts as a byte access at addr carrying data[7:0] (result in rdata[7:0]), followed by a byte access at addr+1 carrying data[15:8] (result in rdata[15:8]). A byte read returns zero in rdata[15:8].
- R10: `cpu_ready` drops in the cycle after a request is accepted. Each byte-or-aligned-word part holds it low for two cycles when it is a read or a merge-mode write: a read of all planes, then the write. Other parts hold it low for one cycle. No memory cycle occurs while `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_sel | input | 1 | 0 = mode byte, 1 = tile byte |
| io_wdata | input | 8 | I/O write data |
| cpu_req | input | 1 | Access request, accepted while cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte |
| cpu_addr | input | OFFSET_BITS+2 | Byte address; top two bits pick the plane for plain accesses |
| cpu_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| cpu_ready | output | 1 | High when idle; low while an access runs |
| cpu_rdata | output | 16 | Read result, valid once cpu_ready returns high |
| mem_en | output | 1 | Memory cycle strobe |
| mem_we | output | 4 | Per-plane write enables (all zero = read) |
| mem_be | output | 2 | Byte lane enables of the 16-bit plane word |
| mem_addr | output | OFFSET_BITS-1 | Word address inside each plane |
| mem_wdata | output | 64 | Write data, 16 bits per plane, plane 0 lowest |
| mem_rdata | input | 64 | Read data from all planes, one cycle after a read cycle |

## Verification
The bench builds the unit with OFFSET_BITS=4, giving eight words per plane. This small memory lets the full contents of all four planes be compared with a byte-wise array model after every access. It also lets the sweep over all sixteen plane-disable patterns land merge, direct and compare accesses on overlapping bytes, so earlier fills meet later compares. Odd-address words, tile-pointer wrap and mode bits with no effect are all reached within a few hundred accesses.

// File: rtl/tru_pkg.sv
package tru_pkg;
  localparam int NPLANES = 4;
  localparam int PSEL_W  = $clog2(NPLANES);
  localparam int LANE_W  = 16;

  // mode byte as stored: enable (byte bit 7), merge (bit 6), plane-off flags (bits 3:0)
  typedef struct packed {
    logic               chg_en;
    logic               merge;
    logic [NPLANES-1:0] pl_off;
  } mode_t;

  function automatic logic [LANE_W-1:0] tile_word(input logic [7:0] t);
    return {t, t};
  endfunction

  function automatic logic [LANE_W-1:0] rmw_merge(input logic [LANE_W-1:0] old,
                                                  input logic [LANE_W-1:0] tw,
                                                  input logic [LANE_W-1:0] m);
    return (old & ~m) | (tw & m);
  endfunction
endpackage

// File: rtl/tru_regs.sv
module tru_regs import tru_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_wr,
  input  logic                io_sel,
  input  logic [7:0]          io_wdata,
  output mode_t               mode,
  output logic [NPLANES*8-1:0] tiles,
  output logic [PSEL_W-1:0]   tile_ptr,
  output logic                mode_wr
);
  logic tile_wr;
  assign mode_wr = io_wr && !io_sel;
  assign tile_wr = io_wr && io_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      tile_ptr <= '0;
    end else if (mode_wr) begin
      mode     <= mode_t'({io_wdata[7:6], io_wdata[NPLANES-1:0]});
      tile_ptr <= '0;
    end else if (tile_wr) begin
      tile_ptr <= tile_ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < NPLANES; i++) begin : g_tile
    always_ff @(posedge clk) begin
      if (!rst_n)
        tiles[i*8 +: 8] <= '0;
      else if (tile_wr && tile_ptr == PSEL_W'(i))
        tiles[i*8 +: 8] <= io_wdata;
    end
  end
endmodule

// File: rtl/tru_lanes.sv
module tru_lanes import tru_pkg::*; (
  input  mode_t                      op_mode,
  input  logic [NPLANES*8-1:0]       tiles,
  input  logic [PSEL_W-1:0]          psel,
  input  logic [LANE_W-1:0]          d16,
  input  logic [NPLANES*LANE_W-1:0]  old,
  output logic [NPLANES*LANE_W-1:0]  wbus,
  output logic [NPLANES-1:0]         we_mask,
  output logic [LANE_W-1:0]          rd16
);
  logic [NPLANES*LANE_W-1:0] diff;
  logic [LANE_W-1:0]         any_diff;

  for (genvar i = 0; i < NPLANES; i++) begin : g_plane
    logic [LANE_W-1:0] tw;
    logic [LANE_W-1:0] oldp;
    logic              en;
    assign tw   = tile_word(tiles[i*8 +: 8]);
    assign oldp = old[i*LANE_W +: LANE_W];
    assign en   = !op_mode.pl_off[i];
    assign wbus[i*LANE_W +: LANE_W] = !op_mode.chg_en ? d16 :
                                      (op_mode.merge ? rmw_merge(oldp, tw, d16) : tw);
    assign we_mask[i] = op_mode.chg_en ? en : (psel == PSEL_W'(i));
    assign diff[i*LANE_W +: LANE_W] = en ? (oldp ^ tw) : '0;
  end

  always_comb begin
    any_diff = '0;
    for (int i = 0; i < NPLANES; i++) any_diff = any_diff | diff[i*LANE_W +: LANE_W];
  end

  assign rd16 = (op_mode.chg_en && !op_mode.merge) ? ~any_diff : old[psel*LANE_W +: LANE_W];
endmodule

// File: rtl/tru_seq.sv
module tru_seq import tru_pkg::*; #(
  parameter int OFFSET_BITS = 10,
  localparam int AW  = OFFSET_BITS + PSEL_W,
  localparam int WAW = OFFSET_BITS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_word,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [LANE_W-1:0] cpu_wdata,
  input  mode_t             mode_in,
  input  logic [LANE_W-1:0] rd16,
  output logic              cpu_ready,
  output logic [LANE_W-1:0] cpu_rdata,
  output mode_t             op_mode,
  output logic [PSEL_W-1:0] psel,
  output logic [LANE_W-1:0] d16,
  output logic [1:0]        mem_be,
  output logic [WAW-1:0]    mem_addr,
  output logic              issue_rd,
  output logic              issue_wr
);
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DAT} st_t;
  st_t               st;
  logic              op_we, op_word, op_split, part;
  logic [AW-1:0]     op_addr, pa;
  logic [LANE_W-1:0] op_wdata;
  logic [7:0]        byte_in, rbyte;
  logic              pw, need_rd, last_part;

  assign pa        = op_addr + AW'(part);
  assign pw        = op_word && !op_split;
  assign byte_in   = (op_split && part) ? op_wdata[15:8] : op_wdata[7:0];
  assign d16       = pw ? op_wdata : tile_word(byte_in);
  assign mem_be    = pw ? 2'b11 : (pa[0] ? 2'b10 : 2'b01);
  assign mem_addr  = pa[OFFSET_BITS-1:1];
  assign psel      = pa[AW-1 -: PSEL_W];
  assign need_rd   = !op_we || (op_mode.chg_en && op_mode.merge);
  assign last_part = !op_split || part;
  assign issue_rd  = (st == S_ACC) && need_rd;
  assign issue_wr  = ((st == S_ACC) && !need_rd) || ((st == S_DAT) && op_we);
  assign rbyte     = pa[0] ? rd16[15:8] : rd16[7:0];
  assign cpu_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_we     <= 1'b0;
      op_word   <= 1'b0;
      op_split  <= 1'b0;
      part      <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
      op_mode   <= '0;
      cpu_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          op_we    <= cpu_we;
          op_word  <= cpu_word;
          op_split <= cpu_word && cpu_addr[0];
          op_addr  <= cpu_addr;
          op_wdata <= cpu_wdata;
          op_mode  <= mode_in;
          part     <= 1'b0;
          st       <= S_ACC;
        end
        S_ACC: begin
          if (need_rd)        st <= S_DAT;
          else if (last_part) st <= S_IDLE;
          else begin part <= 1'b1; st <= S_ACC; end
        end
        S_DAT: begin
          if (!op_we) begin
            if (pw)                   cpu_rdata <= rd16;
            else if (op_split && part) cpu_rdata[15:8] <= rbyte;
            else if (op_split)         cpu_rdata[7:0] <= rbyte;
            else                       cpu_rdata <= {8'h00, rbyte};
          end
          if (last_part) st <= S_IDLE;
          else begin part <= 1'b1; st <= S_ACC; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_raster_unit.sv
module tile_raster_unit import tru_pkg::*; #(
  parameter int OFFSET_BITS = 10,
  localparam int AW  = OFFSET_BITS + PSEL_W,
  localparam int WAW = OFFSET_BITS - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      io_wr,
  input  logic                      io_sel,
  input  logic [7:0]                io_wdata,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic                      cpu_word,
  input  logic [AW-1:0]             cpu_addr,
  input  logic [LANE_W-1:0]         cpu_wdata,
  output logic                      cpu_ready,
  output logic [LANE_W-1:0]         cpu_rdata,
  output logic                      mem_en,
  output logic [NPLANES-1:0]        mem_we,
  output logic [1:0]                mem_be,
  output logic [WAW-1:0]            mem_addr,
  output logic [NPLANES*LANE_W-1:0] mem_wdata,
  input  logic [NPLANES*LANE_W-1:0] mem_rdata
);
  mode_t                mode, op_mode;
  logic [NPLANES*8-1:0] tiles;
  logic [PSEL_W-1:0]    tile_ptr, psel;
  logic                 mode_wr;
  logic [LANE_W-1:0]    d16, rd16;
  logic [NPLANES-1:0]   we_mask;
  logic                 ev_rd, ev_wr;

  tru_regs u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel), .io_wdata(io_wdata),
    .mode(mode), .tiles(tiles), .tile_ptr(tile_ptr), .mode_wr(mode_wr)
  );

  tru_seq #(.OFFSET_BITS(OFFSET_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mode_in(mode), .rd16(rd16),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .op_mode(op_mode), .psel(psel),
    .d16(d16), .mem_be(mem_be), .mem_addr(mem_addr), .issue_rd(ev_rd), .issue_wr(ev_wr)
  );

  tru_lanes u_lanes (
    .op_mode(op_mode), .tiles(tiles), .psel(psel), .d16(d16), .old(mem_rdata),
    .wbus(mem_wdata), .we_mask(we_mask), .rd16(rd16)
  );

  assign mem_en = ev_rd || ev_wr;
  assign mem_we = ev_wr ? we_mask : '0;
endmodule

// File: rtl/tile_raster_unit_chk.sv
module tile_raster_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr,
  input logic [1:0] tile_ptr,
  input logic [5:0] op_mode_bits,
  input logic       ev_rd,
  input logic       ev_wr,
  input logic [3:0] mem_we,
  input logic       mem_en,
  input logic       cpu_req,
  input logic       cpu_ready
);
  a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (tile_ptr == 2'd0));

  a_r4_off_planes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && op_mode_bits[5]) |-> ((mem_we & op_mode_bits[3:0]) == 4'd0));

  a_r8_single_plane: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && !op_mode_bits[5]) |-> ($countones(mem_we) == 1));

  a_r10_read_before_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && op_mode_bits[5] && op_mode_bits[4]) |-> $past(ev_rd));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_en);
endmodule

bind tile_raster_unit tile_raster_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .tile_ptr(tile_ptr),
  .op_mode_bits(op_mode), .ev_rd(ev_rd), .ev_wr(ev_wr), .mem_we(mem_we),
  .mem_en(mem_en), .cpu_req(cpu_req), .cpu_ready(cpu_ready)
);

// File: tb/test_tile_raster_unit.sv
module test_tile_raster_unit;
  import tru_pkg::*;
  localparam int OFF   = 4;
  localparam int AW    = OFF + 2;
  localparam int WORDS = 2 ** (OFF - 1);
  localparam int BYTES = 2 ** OFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, io_wr, io_sel, cpu_req, cpu_we, cpu_word, cpu_ready, mem_en;
  logic [7:0]  io_wdata;
  logic [AW-1:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [3:0]  mem_we;
  logic [1:0]  mem_be;
  logic [OFF-2:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  tile_raster_unit #(.OFFSET_BITS(OFF)) i_tile_raster_unit (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel), .io_wdata(io_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // four-plane synchronous memory
  logic [15:0] bmem [NPLANES][WORDS];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPLANES; p++)
        for (int w = 0; w < WORDS; w++) bmem[p][w] <= '0;
    end else if (mem_en) begin
      for (int p = 0; p < NPLANES; p++) begin
        if (mem_we[p] && mem_be[0]) bmem[p][mem_addr][7:0]  <= mem_wdata[p*16 +: 8];
        if (mem_we[p] && mem_be[1]) bmem[p][mem_addr][15:8] <= mem_wdata[p*16+8 +: 8];
        mem_rdata[p*16 +: 16] <= bmem[p][mem_addr];
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { bit rd; logic [15:0] exp; int cyc; string req; } exp_t;
  exp_t q[$];

  logic [7:0] sh [NPLANES][BYTES];
  logic [7:0] m_mode;
  logic [7:0] m_tile [NPLANES];
  int m_ptr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_byte(input bit we, input logic [AW-1:0] a, input logic [7:0] d,
                            output logic [7:0] r);
    int p = int'(a[AW-1:AW-2]);
    int o = int'(a[OFF-1:0]);
    r = 8'h00;
    if (!m_mode[7]) begin
      if (we) sh[p][o] = d; else r = sh[p][o];
    end else if (m_mode[6]) begin
      if (we) begin
        for (int i = 0; i < NPLANES; i++)
          if (!m_mode[i])
            for (int b = 0; b < 8; b++) if (d[b]) sh[i][o][b] = m_tile[i][b];
      end else r = sh[p][o];
    end else begin
      if (we) begin
        for (int i = 0; i < NPLANES; i++) if (!m_mode[i]) sh[i][o] = m_tile[i];
      end else begin
        for (int b = 0; b < 8; b++) begin
          r[b] = 1'b1;
          for (int i = 0; i < NPLANES; i++)
            if (!m_mode[i] && sh[i][o][b] != m_tile[i][b]) r[b] = 1'b0;
        end
      end
    end
  endtask

  task automatic io_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_sel = sel; io_wdata = d;
    if (!sel) begin m_mode = d; m_ptr = 0; end
    else begin m_tile[m_ptr] = d; m_ptr = (m_ptr + 1) % NPLANES; end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cpu_op(input bit we, input bit word, input logic [AW-1:0] a,
                        input logic [15:0] d, input string req);
    exp_t e;
    logic [7:0] r0, r1;
    int per;
    model_byte(we, a, d[7:0], r0);
    r1 = 8'h00;
    if (word) model_byte(we, a + 1'b1, d[15:8], r1);
    per = (!we || (m_mode[7] && m_mode[6])) ? 2 : 1;
    e.rd = !we; e.exp = {r1, r0}; e.req = req;
    e.cyc = (word && a[0]) ? 2 * per : per;
    q.push_back(e);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_word = word; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops one expected item at the end of each access
  int busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cpu_ready) busy++;
      else if (busy > 0) begin
        exp_t e;
        bit mem_ok = 1;
        logic [31:0] bad_a = 0, bad_e = 0;
        if (q.size() == 0) begin
          check(0, "R10", "unexpected completion", 0, 0);
        end else begin
          e = q.pop_front();
          check(busy == e.cyc, e.req == "" ? "R10" : {e.req, " R10"}, "busy cycles", busy, e.cyc);
          if (e.rd) check(cpu_rdata == e.exp, e.req, "rdata", cpu_rdata, e.exp);
          for (int p = 0; p < NPLANES; p++)
            for (int o = 0; o < BYTES; o++)
              if (mem_ok && bmem[p][o/2][8*(o%2) +: 8] !== sh[p][o]) begin
                mem_ok = 0; bad_a = p * 256 + o;
                bad_e = {8'h00, bad_a[15:0], sh[p][o]};
                bad_a = {bad_a[23:0], bmem[p][o/2][8*(o%2) +: 8]};
              end
          check(mem_ok, e.req, "plane memory (plane/offset/byte)", bad_a, bad_e);
        end
        busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_wr = 0; io_sel = 0; io_wdata = 0;
    cpu_req = 0; cpu_we = 0; cpu_word = 0; cpu_addr = 0; cpu_wdata = 0;
    m_mode = 8'h00; m_ptr = 0;
    for (int i = 0; i < NPLANES; i++) m_tile[i] = 8'h00;
    for (int p = 0; p < NPLANES; p++) for (int o = 0; o < BYTES; o++) sh[p][o] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cpu_ready == 1'b1, "R1", "cpu_ready", cpu_ready, 1);
    check(mem_en == 1'b0, "R1", "mem_en", mem_en, 0);
    check(cpu_rdata == 16'h0, "R1", "cpu_rdata", cpu_rdata, 0);
    // R1: first write after reset is a plain single-plane write
    cpu_op(1, 1, {2'd2, 4'd4}, 16'hBEEF, "R1");

    // R8: plain fill of all planes, then plain reads
    for (int p = 0; p < NPLANES; p++)
      for (int o = 0; o < BYTES; o += 2)
        cpu_op(1, 1, {2'(p), 4'(o)}, 16'(p * 16'h1111 ^ o * 16'h0907 ^ 16'hA55A), "R8");
    cpu_op(1, 0, {2'd1, 4'd7}, 16'h00C3, "R8");
    cpu_op(0, 1, {2'd3, 4'd6}, 16'h0, "R8");
    cpu_op(0, 0, {2'd1, 4'd7}, 16'h0, "R8");
    cpu_op(0, 0, {2'd0, 4'd2}, 16'h0, "R9");
    cpu_op(1, 1, {2'd2, 4'd9}, 16'h7E81, "R9");
    cpu_op(0, 1, {2'd2, 4'd9}, 16'h0, "R9");

    // R2: tile pointer wrap, then mode write clears pointer
    io_write(1, 8'hA5); io_write(1, 8'h3C); io_write(1, 8'hF0);
    io_write(1, 8'h0F); io_write(1, 8'h81);
    io_write(0, 8'h80);
    io_write(1, 8'h11);
    cpu_op(1, 0, {2'd0, 4'd12}, 16'h0055, "R2");
    cpu_op(1, 1, {2'd0, 4'd14}, 16'h1234, "R2");

    for (int dis = 0; dis < 16; dis++) begin
      // merge mode
      io_write(0, 8'hC0 | 8'(dis));
      for (int i = 0; i < NPLANES; i++) io_write(1, 8'(8'h1F * (dis + 1)) ^ 8'(i * 8'h47));
      cpu_op(1, 0, {2'(dis % 4), 4'(dis)}, 16'h005A, "R4");
      cpu_op(1, 1, {2'd1, 4'(dis & 14)}, 16'hC33C, "R4");
      cpu_op(1, 1, {2'd2, 4'(dis | 1)}, 16'h0FF0, "R9");
      cpu_op(0, 1, {2'(dis % 4), 4'(dis & 14)}, 16'h0, "R7");
      cpu_op(0, 0, {2'(3 - dis % 4), 4'(dis | 1)}, 16'h0, "R7");
      // direct mode; bits 5:4 set but have no effect
      io_write(0, 8'hB0 | 8'(dis));
      for (int i = 0; i < NPLANES; i++) io_write(1, 8'(8'h2D * (dis + 3)) ^ 8'(i * 8'h39));
      cpu_op(1, 1, {2'd3, 4'((dis + 2) & 14)}, 16'hFFFF, "R3 R5");
      cpu_op(1, 0, {2'd0, 4'((dis + 5) & 15)}, 16'h0000, "R5");
      cpu_op(0, 1, {2'd0, 4'((dis + 2) & 14)}, 16'h0, "R6");
      cpu_op(0, 0, {2'd1, 4'(dis)}, 16'h0, "R6");
      cpu_op(0, 1, {2'd2, 4'(dis | 1)}, 16'h0, "R6 R9");
    end

    // R3: charger off again, plain reads of every plane
    io_write(0, 8'h4F);
    for (int p = 0; p < NPLANES; p++) cpu_op(0, 1, {2'(p), 4'(2 * p)}, 16'h0, "R3 R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule